// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block holds the per-channel control and status state for a four-channel DMA engine. Each channel has one 8-bit register on a simple memory-mapped bus, and the bus can write a whole byte or a single bit. Each register carries four things. The first is an enable level, which the transfer engine reads directly. The second is a retain-mode bit that decides whether enable survives the end of a transfer. The third is a completion flag, which the engine sets and a register read clears. The last is two command bits that are never stored.

The command bits go to the transfer engine as one-cycle pulses. The force-terminate command aborts the channel and drops its enable. The software-start command is accepted only while the channel is enabled and its completion flag is clear. A shared NMI input drops the enable of every channel at once. Address generation, byte counting and data movement belong to the engine and are not part of this block.

Top module: `dma_chctl_bank`

## Requirements
- R1: While `rst` is high and on the first cycle after it, every register is 0x00. `bus_rdata`, `chan_en`, `start_req` and `term_req` are all zero.
- R2: A byte read returns the register in this layout: bit 7 is the completion flag, bit 3 is retain mode and bit 0 is enable. Bits 6 to 4, bit 2 and bit 1 always read 0. The data appears on `bus_rdata` in the cycle after the read strobe.
- R3: A `tc_in[k]` pulse sets channel k's completion flag. A read of that register returns the flag as 1 and clears it. If a read and a `tc_in[k]` pulse fall in the same cycle, the flag stays 1.
- R4: With retain mode at 1, a `tc_in[k]` pulse leaves `chan_en[k]` at 1.
- R5: With retain mode at 0, a `tc_in[k]` pulse clears `chan_en[k]` in the next cycle.
- R6: A write with bit 2 at 1 gives a one-cycle `term_req[k]` pulse in the next cycle. It also clears enable in that same cycle, even if the same write sets bit 0.
- R7: A write with bit 1 at 1 gives a one-cycle `start_req[k]` pulse in the next cycle, but only if enable is 1 and the completion flag is 0 before the write. Otherwise no pulse is produced.
- R8: An `nmi` pulse clears `chan_en` of every channel in the next cycle.
- R9: Channel k sits at byte offset 2k. A write to an odd offset changes nothing, and a read of an odd offset returns 0x00.
- R10: When `bus_bitwr` is 1, a write changes only bit `bus_bitsel` to `bus_wdata[0]`. Writes to bit 7 or to bits 6 to 4 have no effect in either byte or bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Byte read strobe, one cycle |
| bus_addr | input | AW (3) | Byte offset within the bank |
| bus_bitwr | input | 1 | 1: single-bit write, 0: byte write |
| bus_bitsel | input | 3 | Bit position for a single-bit write |
| bus_wdata | input | 8 | Write data (bit 0 is the value in bit mode) |
| bus_rdata | output | 8 | Registered read data |
| tc_in | input | NCH (4) | Terminal-count pulse per channel from the engine |
| nmi | input | 1 | Shared NMI pulse, clears all enables |
| start_req | output | NCH (4) | Software-start pulse per channel |
| term_req | output | NCH (4) | Force-terminate pulse per channel |
| chan_en | output | NCH (4) | Current enable level per channel |

## Verification
The assertions check several rules on every cycle:
- the reset state;
- the read bits that must stay zero;
- an NMI emptying every enable;
- a terminal count setting the flag, and clearing enable when retain mode is off;
- no start pulse leaving a disabled channel;
- a terminate pulse never appearing beside a live enable.

Only the directed scenarios can show the rest. These are the read-clears-flag sequence and its collision with a terminal count, and the start gate refusing a channel whose flag is still set. They also cover the bank's decoding of even and odd offsets, and single-bit writes leaving their neighbours untouched.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = $clog2(REG_W);
  localparam int B_FLAG  = 7;
  localparam int B_MODE  = 3;
  localparam int B_TERM  = 2;
  localparam int B_START = 1;
  localparam int B_EN    = 0;
endpackage

// File: rtl/dma_chctl_dec.sv
module dma_chctl_dec
  import dmactl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_bitwr,
  input  logic [SEL_W-1:0] bus_bitsel,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [NCH-1:0]   wr_hit,
  output logic [NCH-1:0]   rd_hit,
  output logic [REG_W-1:0] wmask,
  output logic [REG_W-1:0] wval,
  output logic             rd_valid,
  output logic [AW-2:0]    rd_idx
);
  logic addr_ok;

  assign rd_idx  = bus_addr[AW-1:1];
  assign addr_ok = !bus_addr[0] && (int'(rd_idx) < NCH);
  assign rd_valid = bus_rd && addr_ok;

  always_comb begin
    if (bus_bitwr) begin
      wmask = '0;
      wmask[bus_bitsel] = 1'b1;
      wval  = {REG_W{bus_wdata[0]}};
    end else begin
      wmask = '1;
      wval  = bus_wdata;
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_hit
    assign wr_hit[k] = bus_wr && addr_ok && (int'(rd_idx) == k);
    assign rd_hit[k] = rd_valid && (int'(rd_idx) == k);
  end
endmodule

// File: rtl/dma_chctl_reg.sv
module dma_chctl_reg
  import dmactl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [REG_W-1:0] wmask,
  input  logic [REG_W-1:0] wval,
  input  logic             tc,
  input  logic             nmi,
  output logic             flag_o,
  output logic             mode_o,
  output logic             en_o,
  output logic             start_o,
  output logic             term_o
);
  logic term_cmd, start_cmd;

  assign term_cmd  = wr_hit && wmask[B_TERM]  && wval[B_TERM];
  assign start_cmd = wr_hit && wmask[B_START] && wval[B_START];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      mode_o  <= 1'b0;
      en_o    <= 1'b0;
      start_o <= 1'b0;
      term_o  <= 1'b0;
    end else begin
      // a completion arriving with a clearing read wins
      if (tc)          flag_o <= 1'b1;
      else if (rd_hit) flag_o <= 1'b0;

      if (wr_hit && wmask[B_MODE]) mode_o <= wval[B_MODE];

      if (nmi || term_cmd)             en_o <= 1'b0;
      else if (tc && !mode_o)          en_o <= 1'b0;
      else if (wr_hit && wmask[B_EN])  en_o <= wval[B_EN];

      start_o <= start_cmd && en_o && !flag_o;
      term_o  <= term_cmd;
    end
  end
endmodule

// File: rtl/dma_chctl_rdmux.sv
module dma_chctl_rdmux
  import dmactl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic             bus_rd,
  input  logic [AW-2:0]    rd_idx,
  input  logic [NCH-1:0]   flag_v,
  input  logic [NCH-1:0]   mode_v,
  input  logic [NCH-1:0]   en_v,
  output logic [REG_W-1:0] rdata
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = '0;
    for (int k = 0; k < NCH; k++) begin
      if (int'(rd_idx) == k) begin
        word[B_FLAG] = flag_v[k];
        word[B_MODE] = mode_v[k];
        word[B_EN]   = en_v[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (bus_rd) rdata <= rd_valid ? word : '0;
  end
endmodule

// File: rtl/dma_chctl_bank.sv
module dma_chctl_bank
  import dmactl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = $clog2(NCH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_bitwr,
  input  logic [SEL_W-1:0] bus_bitsel,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic [NCH-1:0]   tc_in,
  input  logic             nmi,
  output logic [NCH-1:0]   start_req,
  output logic [NCH-1:0]   term_req,
  output logic [NCH-1:0]   chan_en
);
  logic [NCH-1:0]   wr_hit, rd_hit, flag_q, mode_q;
  logic [REG_W-1:0] wmask, wval;
  logic             rd_valid;
  logic [AW-2:0]    rd_idx;

  dma_chctl_dec #(.NCH(NCH), .AW(AW)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_bitwr(bus_bitwr), .bus_bitsel(bus_bitsel), .bus_wdata(bus_wdata),
    .wr_hit(wr_hit), .rd_hit(rd_hit), .wmask(wmask), .wval(wval),
    .rd_valid(rd_valid), .rd_idx(rd_idx)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    dma_chctl_reg u_reg (
      .clk(clk), .rst(rst), .wr_hit(wr_hit[k]), .rd_hit(rd_hit[k]),
      .wmask(wmask), .wval(wval), .tc(tc_in[k]), .nmi(nmi),
      .flag_o(flag_q[k]), .mode_o(mode_q[k]), .en_o(chan_en[k]),
      .start_o(start_req[k]), .term_o(term_req[k])
    );
  end

  dma_chctl_rdmux #(.NCH(NCH), .AW(AW)) u_rdmux (
    .clk(clk), .rst(rst), .rd_valid(rd_valid), .bus_rd(bus_rd),
    .rd_idx(rd_idx), .flag_v(flag_q), .mode_v(mode_q), .en_v(chan_en),
    .rdata(bus_rdata)
  );
endmodule

// File: rtl/dma_chctl_chk.sv
module dma_chctl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           nmi,
  input logic           bus_wr,
  input logic [NCH-1:0] tc_in,
  input logic [NCH-1:0] start_req,
  input logic [NCH-1:0] term_req,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] flag_q,
  input logic [NCH-1:0] mode_q,
  input logic [7:0]     bus_rdata
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (chan_en == '0 && start_req == '0 && term_req == '0 && bus_rdata == 8'h00));

  // R2
  zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata[6:4] == 3'b000 && bus_rdata[2:1] == 2'b00));

  // R8
  nmi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    nmi |=> (chan_en == '0));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R3
    tc_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      tc_in[k] |=> flag_q[k]);

    // R5
    tc_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
      (tc_in[k] && !mode_q[k]) |=> !chan_en[k]);

    // R6
    term_no_en_chk: assert property (@(posedge clk) disable iff (rst)
      term_req[k] |-> !chan_en[k]);

    // R7
    start_gated_chk: assert property (@(posedge clk) disable iff (rst)
      start_req[k] |-> ($past(chan_en[k]) && !$past(flag_q[k]) && $past(bus_wr)));
  end
endmodule

bind dma_chctl_bank dma_chctl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .nmi(nmi), .bus_wr(bus_wr), .tc_in(tc_in),
  .start_req(start_req), .term_req(term_req), .chan_en(chan_en),
  .flag_q(flag_q), .mode_q(mode_q), .bus_rdata(bus_rdata)
);

// File: tb/test_dma_chctl_bank.sv
module test_dma_chctl_bank;
  localparam int NCH = 4;
  localparam int AW  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_bitwr = 1'b0, nmi = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [2:0]    bus_bitsel = '0;
  logic [7:0]    bus_wdata = '0, bus_rdata;
  logic [NCH-1:0] tc_in = '0, start_req, term_req, chan_en;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_chctl_bank #(.NCH(NCH)) i_dma_chctl_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_bitwr(bus_bitwr), .bus_bitsel(bus_bitsel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tc_in(tc_in), .nmi(nmi), .start_req(start_req),
    .term_req(term_req), .chan_en(chan_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, release at the next one; outputs then show the result
  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d; bus_bitwr = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_bit(input int a, input int pos, input logic v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_bitwr = 1'b1;
    bus_bitsel = 3'(pos); bus_wdata = {7'b0, v};
    @(negedge clk);
    bus_wr = 1'b0; bus_bitwr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_tc(input int k);
    @(negedge clk);
    tc_in[k] = 1'b1;
    @(negedge clk);
    tc_in = '0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    for (int k = 0; k < NCH; k++) begin
      wr_byte(2 * k, 8'h00);
      rd(2 * k, d);
    end
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 chan_en", chan_en, 0);
    chk("R1 start_req", start_req, 0);
    chk("R1 term_req", term_req, 0);
    chk("R1 rdata", bus_rdata, 0);
    for (int k = 0; k < NCH; k++) begin
      rd(2 * k, d);
      chk("R1 reg", d, 8'h00);
    end
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr_byte(0, 8'hF9);
    rd(0, d);
    chk("R2 R10 layout", d, 8'h09);
    chk("R2 enable", chan_en, 4'b0001);
  endtask

  task automatic t_tc_retain();
    logic [7:0] d;
    clear_all();
    wr_byte(2, 8'h09);
    pulse_tc(1);
    chk("R4 en kept", chan_en, 4'b0010);
    rd(2, d);
    chk("R3 flag read", d, 8'h89);
    rd(2, d);
    chk("R3 flag cleared", d, 8'h09);
  endtask

  task automatic t_tc_drop();
    logic [7:0] d;
    clear_all();
    wr_byte(4, 8'h01);
    chk("R5 en before", chan_en, 4'b0100);
    pulse_tc(2);
    chk("R5 en dropped", chan_en, 4'b0000);
    rd(4, d);
    chk("R3 R5 read", d, 8'h80);
    rd(4, d);
    chk("R3 cleared", d, 8'h00);
  endtask

  task automatic t_tc_collide();
    logic [7:0] d;
    clear_all();
    pulse_tc(3);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'd6; tc_in[3] = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; tc_in = '0;
    chk("R3 collide read", bus_rdata, 8'h80);
    rd(6, d);
    chk("R3 collide kept", d, 8'h80);
    rd(6, d);
    chk("R3 collide cleared", d, 8'h00);
  endtask

  task automatic t_start();
    logic [7:0] d;
    clear_all();
    wr_byte(0, 8'h01);
    wr_byte(0, 8'h03);
    chk("R7 start pulse", start_req, 4'b0001);
    @(negedge clk);
    chk("R7 pulse one cycle", start_req, 4'b0000);
    wr_byte(4, 8'h02);
    chk("R7 disabled no start", start_req, 4'b0000);
    wr_byte(2, 8'h09);
    pulse_tc(1);
    wr_byte(2, 8'h0B);
    chk("R7 flag blocks start", start_req, 4'b0000);
    rd(2, d);
    wr_byte(2, 8'h0B);
    chk("R7 start after read", start_req, 4'b0010);
  endtask

  task automatic t_term();
    logic [7:0] d;
    clear_all();
    wr_byte(2, 8'h01);
    wr_byte(2, 8'h0D);
    chk("R6 term pulse", term_req, 4'b0010);
    chk("R6 en cleared", chan_en, 4'b0000);
    @(negedge clk);
    chk("R6 pulse one cycle", term_req, 4'b0000);
    rd(2, d);
    chk("R6 readback", d, 8'h08);
  endtask

  task automatic t_bits();
    logic [7:0] d;
    clear_all();
    wr_bit(4, 0, 1'b1);
    rd(4, d);
    chk("R10 bit0", d, 8'h01);
    wr_bit(4, 3, 1'b1);
    rd(4, d);
    chk("R10 bit3", d, 8'h09);
    wr_bit(4, 0, 1'b0);
    rd(4, d);
    chk("R10 bit0 clear", d, 8'h08);
    wr_bit(4, 7, 1'b1);
    wr_bit(4, 5, 1'b1);
    rd(4, d);
    chk("R10 flag reserved", d, 8'h08);
  endtask

  task automatic t_nmi();
    clear_all();
    for (int k = 0; k < NCH; k++) wr_byte(2 * k, 8'h09);
    chk("R8 all enabled", chan_en, 4'b1111);
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R8 nmi clears", chan_en, 4'b0000);
  endtask

  task automatic t_addr();
    logic [7:0] d;
    clear_all();
    wr_byte(1, 8'h09);
    chk("R9 odd write", chan_en, 4'b0000);
    rd(1, d);
    chk("R9 odd read", d, 8'h00);
    wr_byte(4, 8'h01);
    chk("R9 offset 4", chan_en, 4'b0100);
    wr_byte(6, 8'h01);
    chk("R9 offset 6", chan_en, 4'b1100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", chan_en, 0);
    rst = 1'b0;
    t_reset();
    t_layout();
    t_tc_retain();
    t_tc_drop();
    t_tc_collide();
    t_start();
    t_term();
    t_bits();
    t_nmi();
    t_addr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule